// File: doc/BRIEF.md
# Coin Vending Controller

This block is the control core of a small vending machine. It takes two coin inputs, one for a 5-unit coin and one for a 10-unit coin, and sells an item that costs 15 units. It keeps the credit collected so far as one of three states. When a coin brings the credit to the price, it releases the item in the same cycle. When a coin takes the credit past the price, it also returns one 5-unit coin. After a sale it goes back to zero credit.

The outputs are Mealy outputs. They come straight from the current state and the coin inputs, so they are valid only late in the cycle, ahead of the edge that captures the coin. The coin sensor gives a one-cycle pulse for each coin.

The states are named as follows:
- `CR_ZERO` (code 00) holds no credit.
- `CR_FIVE` (01) holds 5 units.
- `CR_TEN` (10) holds 10 units.
- `CR_BAD` (11) can never be reached. If it is ever entered, the block returns to `CR_ZERO`.

The transitions are named as follows:
- `ZERO->FIVE` on a 5-unit coin.
- `ZERO->TEN` on a 10-unit coin.
- `FIVE->TEN` on a 5-unit coin.
- `FIVE->ZERO` on a 10-unit coin (sale).
- `TEN->ZERO` on a 5-unit coin (sale).
- `TEN->ZERO` on a 10-unit coin (sale with change).
- `BAD->ZERO` on any input.
- A self-loop in every valid state when no coin arrives.

Top module: `coin_vend_ctrl`

## Requirements
- R1: `rst` is synchronous and active-high. After a clock edge with `rst` high, the credit is zero. While `rst` is high, `vend` and `change` are 0.
- R2: At zero credit, a 5-unit coin moves the credit to 5 and a 10-unit coin moves it to 10. Neither coin raises `vend` or `change`.
- R3: At 5 units of credit, a 5-unit coin moves the credit to 10 with `vend`=0 and `change`=0.
- R4: At 5 units of credit, a 10-unit coin gives `vend`=1 and `change`=0 in that cycle, and the credit returns to zero.
- R5: At 10 units of credit, a 5-unit coin gives `vend`=1 and `change`=0 in that cycle, and the credit returns to zero.
- R6: At 10 units of credit, a 10-unit coin gives `vend`=1 and `change`=1 in that cycle, and the credit returns to zero. `change` is never 1 unless `vend` is 1.
- R7: A cycle with neither coin input high leaves the credit unchanged, with `vend`=0 and `change`=0.
- R8: A cycle with both coin inputs high counts as no coin. The credit is unchanged, and `vend` and `change` are 0.
- R9: `vend` and `change` follow the coin inputs within the same cycle, with no register in the path. They fall in the first following cycle that has no coin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| coin_5 | input | 1 | One-cycle pulse for a 5-unit coin |
| coin_10 | input | 1 | One-cycle pulse for a 10-unit coin |
| vend | output | 1 | Release the item (Mealy) |
| change | output | 1 | Return one 5-unit coin (Mealy) |

## Verification
The credit can only be seen through the sale outputs. A wrong state therefore stays hidden until the next coin that should, or should not, complete a sale. That can be one coin later, or two if the wrong state is a low credit.

The stimulus table follows every transition. Each wrong credit is followed, within two coins, by a coin that exposes it as a missing or extra `vend` or `change`. Reset and double-coin cycles are each followed by a coin whose result depends on the credit they should have left behind.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;
    localparam int CREDIT_W = 2;

    typedef enum logic [CREDIT_W-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_BAD  = 2'b11
    } credit_t;

    typedef enum logic [1:0] {
        COIN_NONE = 2'd0,
        COIN_FIVE = 2'd1,
        COIN_TEN  = 2'd2
    } coin_t;
endpackage

// File: rtl/coin_classify.sv
module coin_classify
    import coin_vend_pkg::*;
(
    input  logic  coin_5,
    input  logic  coin_10,
    output coin_t ev
);
    // Both pulses at once are rejected as no coin.
    always_comb begin
        unique case ({coin_10, coin_5})
            2'b01:   ev = COIN_FIVE;
            2'b10:   ev = COIN_TEN;
            default: ev = COIN_NONE;
        endcase
    end
endmodule

// File: rtl/credit_step.sv
module credit_step
    import coin_vend_pkg::*;
(
    input  credit_t cur,
    input  coin_t   ev,
    output credit_t nxt,
    output logic    vend,
    output logic    change
);
    always_comb begin
        nxt    = cur;
        vend   = 1'b0;
        change = 1'b0;
        unique case (cur)
            CR_ZERO: begin
                if (ev == COIN_FIVE)     nxt = CR_FIVE;
                else if (ev == COIN_TEN) nxt = CR_TEN;
            end
            CR_FIVE: begin
                if (ev == COIN_FIVE) nxt = CR_TEN;
                else if (ev == COIN_TEN) begin
                    nxt  = CR_ZERO;
                    vend = 1'b1;
                end
            end
            CR_TEN: begin
                if (ev == COIN_FIVE) begin
                    nxt  = CR_ZERO;
                    vend = 1'b1;
                end else if (ev == COIN_TEN) begin
                    nxt    = CR_ZERO;
                    vend   = 1'b1;
                    change = 1'b1;
                end
            end
            default: nxt = CR_ZERO;
        endcase
    end
endmodule

// File: rtl/credit_reg.sv
module credit_reg
    import coin_vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  credit_t nxt,
    output credit_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= CR_ZERO;
        else     cur <= nxt;
    end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import coin_vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic coin_5,
    input  logic coin_10,
    output logic vend,
    output logic change
);
    coin_t   ev;
    credit_t cur_state;
    credit_t nxt_state;
    logic    vend_raw;
    logic    change_raw;

    coin_classify u_classify (
        .coin_5 (coin_5),
        .coin_10(coin_10),
        .ev     (ev)
    );

    credit_step u_step (
        .cur   (cur_state),
        .ev    (ev),
        .nxt   (nxt_state),
        .vend  (vend_raw),
        .change(change_raw)
    );

    credit_reg u_reg (
        .clk(clk),
        .rst(rst),
        .nxt(nxt_state),
        .cur(cur_state)
    );

    // No sale can be signalled while the machine is held in reset.
    always_comb begin
        vend   = vend_raw & ~rst;
        change = change_raw & ~rst;
    end
endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk
    import coin_vend_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                coin_5,
    input logic                coin_10,
    input logic                vend,
    input logic                change,
    input logic [CREDIT_W-1:0] state
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> state == CR_ZERO);
    // R6
    change_needs_vend_chk: assert property (@(posedge clk) disable iff (rst) change |-> vend);
    // R4
    sale_clears_credit_chk: assert property (@(posedge clk) disable iff (rst) vend |=> state == CR_ZERO);
    // R7
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!coin_5 && !coin_10 && state != CR_BAD) |=> $stable(state));
    // R8
    both_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (coin_5 && coin_10 && state != CR_BAD) |=> $stable(state));
    // R8
    both_no_sale_chk: assert property (@(posedge clk) disable iff (rst)
        (coin_5 && coin_10) |-> !vend && !change);
    // R2
    zero_no_sale_chk: assert property (@(posedge clk) disable iff (rst)
        state == CR_ZERO |-> !vend);
    // R1
    valid_state_chk: assert property (@(posedge clk) disable iff (rst) state != CR_BAD);
endmodule

bind coin_vend_ctrl coin_vend_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .coin_5 (coin_5),
    .coin_10(coin_10),
    .vend   (vend),
    .change (change),
    .state  (cur_state)
);

// File: tb/tb_coin_vend_ctrl.sv
module tb_coin_vend_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coin_5 = 1'b0;
    logic coin_10 = 1'b0;
    logic vend;
    logic change;
    int   n_checks = 0;
    int   n_errors = 0;

    coin_vend_ctrl dut (
        .clk    (clk),
        .rst    (rst),
        .coin_5 (coin_5),
        .coin_10(coin_10),
        .vend   (vend),
        .change (change)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Entry fields: {coin_5, coin_10, expected vend, expected change, requirement[3:0]}
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        8'b10_00_0010, // R2 0 -> 5
        8'b10_00_0011, // R3 5 -> 10
        8'b10_10_0101, // R5 10 -> 0, sale
        8'b01_00_0010, // R2 0 -> 10
        8'b01_11_0110, // R6 10 -> 0, sale with change
        8'b10_00_0010, // R2 0 -> 5
        8'b00_00_0111, // R7 idle at 5
        8'b01_10_0100, // R4 5 -> 0, sale
        8'b01_00_0010, // R2 0 -> 10
        8'b11_00_1000, // R8 both at 10
        8'b00_00_0111, // R7 idle at 10
        8'b10_10_0101, // R5 10 -> 0, sale
        8'b10_00_0010, // R2 0 -> 5
        8'b11_00_1000, // R8 both at 5
        8'b01_10_0100, // R4 5 -> 0, sale
        8'b00_00_1001, // R9 outputs fall without a coin
        8'b01_00_0010, // R2 0 -> 10
        8'b01_11_0110  // R6 10 -> 0, sale with change
    };

    task automatic check(input int req, input logic ev, input logic ec);
        n_checks++;
        if (vend !== ev || change !== ec) begin
            n_errors++;
            $display("FAIL R%0d: vend/change got %b%b expected %b%b", req, vend, change, ev, ec);
        end
    endtask

    task automatic drive(input logic c5, input logic c10);
        @(negedge clk);
        coin_5  = c5;
        coin_10 = c10;
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        // R1: outputs held low during reset even with a coin present
        drive(1'b0, 1'b1);
        check(1, 1'b0, 1'b0);
        @(negedge clk);
        rst     = 1'b0;
        coin_10 = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][7], VEC[i][6]);
            check(int'(VEC[i][3:0]), VEC[i][5], VEC[i][4]);
        end

        // R1: reset from 5 units of credit clears it
        drive(1'b1, 1'b0);
        check(2, 1'b0, 1'b0);
        @(negedge clk);
        coin_5  = 1'b0;
        coin_10 = 1'b1;
        rst     = 1'b1;
        #2;
        check(1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check(1, 1'b0, 1'b0);  // credit 0 -> 10, no sale
        drive(1'b1, 1'b0);
        check(1, 1'b1, 1'b0);  // 10 + 5 proves reset left zero
        // R9: outputs drop in the next coinless cycle
        drive(1'b0, 1'b0);
        check(9, 1'b0, 1'b0);
        // R9: output follows the coin within the cycle
        drive(1'b1, 1'b0);
        check(9, 1'b0, 1'b0);
        drive(1'b0, 1'b1);
        check(9, 1'b1, 1'b0);
        drive(1'b0, 1'b0);
        check(9, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule